// File: doc/BRIEF.md
# Self-Fetching Block Source for a Hash/Cipher Engine

This unit lets a hash or cipher engine pull its input from memory without help. Software does not push words into an input register and no DMA channel is used. Software gives a start address, a block count and an enable bit through a small register port. The unit then reads 32-bit words in sequence over a simple read-master port. It collects each block in a buffer and offers the full block to the engine over a valid/ready handshake.

A block is 16 words in hash mode and 4 words in cipher mode. In cipher mode the first block can be longer, because it may also carry key and IV words. The remaining-block count goes down by one each time the engine accepts a block. In hash mode the digest interrupt fires once, at the end of the job. In cipher mode it fires for every block.

A bus error stops the job. The count is left naming the block that failed and the address register is left at the failing word. A sticky error flag blocks any new start until software clears it.

Top module: `blockFetch`

## Requirements
- R1: After reset, every register reads zero, `memReq`, `blkValid` and `irqDigest` are low, and `irqErr` is low.
- R2: The register selector `regSel` picks one of three registers. Value 0 is control: bit 0 is the enable, bits 26:16 are the 11-bit count, and all other bits read zero. Value 1 is the start/current byte address. Value 2 is status: bit 0 is the sticky error flag.
- R3: A control write starts a job only when the unit is idle, the error flag is clear, bit 0 is 1 and the count field is nonzero. A control write with count 0 or with enable 0 issues no read.
- R4: Reads begin at the programmed address and step by 4 for each word fetched without error. The address register shows the next word to fetch.
- R5: In hash mode (`hashMode`=1) a block is 16 words. In cipher mode a block is 4 words, except the first one, which is 4 plus `keyIvWords` words. `keyIvWords` is clamped to 12.
- R6: `blkValid` rises only after every word of the block has been fetched. Word i appears at `blkData[32*i+:32]` and `blkWords` gives the length. While `blkValid` is high and not yet accepted, the data stays stable and no read is issued.
- R7: The count drops by one on the clock edge where a block is accepted, and the job ends when it reaches 0.
- R8: `irqDigest` pulses for one cycle after an accepted block. In hash mode this happens only for the block that takes the count to 0. In cipher mode it happens for every block.
- R9: A read answered with `memErr` ends the job. The count keeps its value, the address stays on the failing word, the error flag sets, and `irqErr` goes high.
- R10: While the error flag is set, no job can start. Writing 1 to status bit 0 clears the flag.
- R11: Writes to the control and address registers made while a job is running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 control, 1 address, 2 status) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| hashMode | input | 1 | 1 = hash block size, 0 = cipher block size; sampled at start |
| keyIvWords | input | 4 | Extra words in the first cipher block; sampled at start |
| memReq | output | 1 | Read request, held until acknowledged |
| memAddr | output | 32 | Byte address of the read |
| memAck | input | 1 | Read response valid |
| memErr | input | 1 | Response carries a bus error |
| memData | input | 32 | Read response data |
| blkValid | output | 1 | Assembled block offered to the engine |
| blkReady | input | 1 | Engine accepts the block |
| blkData | output | 512 | Block words, word 0 in the low bits |
| blkWords | output | 5 | Number of valid words in blkData |
| irqDigest | output | 1 | One-cycle digest/output interrupt |
| irqErr | output | 1 | Error interrupt, level, follows the error flag |

## Verification
A start write at one edge makes `memReq` high in the very next cycle. Each word then costs one request cycle plus one acknowledge cycle with the bench's memory. The bench therefore waits for `blkValid` with a bounded poll instead of counting fixed cycles. Acceptance is the edge where `blkReady` is high. The count and address read back with their new values at the negedge right after that edge, and `irqDigest` is high during that same following cycle. That is why interrupt totals are taken a few cycles after the last block. The bench drives and samples only at falling edges. Error results are read once `irqErr` has gone high, and "no read issued" checks count `memReq` cycles over a fixed window.

// File: rtl/blockFetchPkg.sv
package blockFetchPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_OFFER
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldAddr;
    logic ldCount;
    logic capWord;
    logic advAddr;
    logic decCount;
  } pathStrobe_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  localparam int CNT_LSB = 16;

endpackage

// File: rtl/blockFetchPath.sv
module blockFetchPath
  import blockFetchPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 16,
  parameter int CNT_W     = 11,
  localparam int SLOT_W   = $clog2(MAX_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  pathStrobe_t                 strobe,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic [CNT_W-1:0]            countIn,
  input  logic [WORD_W-1:0]           memData,
  output logic [ADDR_W-1:0]           addrVal,
  output logic [CNT_W-1:0]            countVal,
  output logic [MAX_WORDS*WORD_W-1:0] blkData
);

  localparam int BYTES_PER_WORD = WORD_W / 8;

  logic [WORD_W-1:0] wordBuf [MAX_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrVal  <= '0;
      countVal <= '0;
    end else begin
      if (strobe.ldAddr)       addrVal <= addrIn;
      else if (strobe.advAddr) addrVal <= addrVal + ADDR_W'(BYTES_PER_WORD);
      if (strobe.ldCount)       countVal <= countIn;
      else if (strobe.decCount) countVal <= countVal - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capWord) wordBuf[slot] <= memData;
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_pack
    assign blkData[g*WORD_W +: WORD_W] = wordBuf[g];
  end

endmodule

// File: rtl/blockFetchCtrl.sv
module blockFetchCtrl
  import blockFetchPkg::*;
#(
  parameter int MAX_WORDS    = 16,
  parameter int CIPHER_WORDS = 4,
  parameter int CNT_W        = 11,
  localparam int SLOT_W      = $clog2(MAX_WORDS),
  localparam int LEN_W       = $clog2(MAX_WORDS + 1),
  localparam int EXTRA_MAX   = MAX_WORDS - CIPHER_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic              wrBit0,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic              hashMode,
  input  logic [SLOT_W-1:0] keyIvWords,
  input  logic [CNT_W-1:0]  countVal,
  input  logic              memAck,
  input  logic              memErr,
  input  logic              blkReady,
  output pathStrobe_t       strobe,
  output logic [SLOT_W-1:0] slot,
  output logic              memReq,
  output logic              blkValid,
  output logic [LEN_W-1:0]  blkWords,
  output logic              irqDigest,
  output logic              enBit,
  output logic              errSticky
);

  fetchState_t state;
  logic modeHashQ, firstBlk;
  logic [SLOT_W-1:0] extraQ, extraClamp;
  logic idle, ctrlWr, startNow, wordOk, wordBad, accept, lastBlk, lastWord;

  assign idle     = (state == ST_IDLE);
  assign ctrlWr   = regWrEn && (regSel == REG_CTRL) && idle;
  assign startNow = ctrlWr && wrBit0 && (wrCount != '0) && !errSticky;
  assign wordOk   = (state == ST_FETCH) && memAck && !memErr;
  assign wordBad  = (state == ST_FETCH) && memAck && memErr;
  assign accept   = (state == ST_OFFER) && blkReady;
  assign lastBlk  = (countVal == CNT_W'(1));

  assign extraClamp = (keyIvWords > SLOT_W'(EXTRA_MAX)) ? SLOT_W'(EXTRA_MAX) : keyIvWords;

  always_comb begin
    if (modeHashQ)     blkWords = LEN_W'(MAX_WORDS);
    else if (firstBlk) blkWords = LEN_W'(CIPHER_WORDS) + LEN_W'(extraQ);
    else               blkWords = LEN_W'(CIPHER_WORDS);
  end
  assign lastWord = (LEN_W'(slot) == blkWords - LEN_W'(1));

  assign strobe.ldAddr   = regWrEn && (regSel == REG_ADDR) && idle;
  assign strobe.ldCount  = ctrlWr;
  assign strobe.capWord  = wordOk;
  assign strobe.advAddr  = wordOk;
  assign strobe.decCount = accept;

  assign memReq   = (state == ST_FETCH);
  assign blkValid = (state == ST_OFFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      slot      <= '0;
      modeHashQ <= 1'b0;
      extraQ    <= '0;
      firstBlk  <= 1'b0;
      enBit     <= 1'b0;
      errSticky <= 1'b0;
      irqDigest <= 1'b0;
    end else begin
      irqDigest <= accept && (!modeHashQ || lastBlk);
      if (ctrlWr) enBit <= wrBit0;
      if (regWrEn && (regSel == REG_STAT) && wrBit0) errSticky <= 1'b0;
      if (wordBad) errSticky <= 1'b1;
      unique case (state)
        ST_IDLE: if (startNow) begin
          state     <= ST_FETCH;
          slot      <= '0;
          modeHashQ <= hashMode;
          extraQ    <= extraClamp;
          firstBlk  <= 1'b1;
        end
        ST_FETCH: begin
          if (wordBad)                   state <= ST_IDLE;
          else if (wordOk && lastWord)   state <= ST_OFFER;
          else if (wordOk)               slot  <= slot + SLOT_W'(1);
        end
        ST_OFFER: if (accept) begin
          firstBlk <= 1'b0;
          slot     <= '0;
          state    <= lastBlk ? ST_IDLE : ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a block never exceeds the buffer nor falls under the cipher size
  a_r5_len_bounds: assert property (@(posedge clk) disable iff (rst)
    blkValid |-> (blkWords >= LEN_W'(CIPHER_WORDS)) && (blkWords <= LEN_W'(MAX_WORDS)));

  // R8: a digest pulse always follows an accepted block
  a_r8_irq_after_accept: assert property (@(posedge clk) disable iff (rst)
    irqDigest |-> $past(blkValid && blkReady));

endmodule

// File: rtl/blockFetch.sv
module blockFetch
  import blockFetchPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WORD_W       = 32,
  parameter int MAX_WORDS    = 16,
  parameter int CIPHER_WORDS = 4,
  parameter int CNT_W        = 11
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  regWrEn,
  input  logic [1:0]                            regSel,
  input  logic [31:0]                           regWrData,
  output logic [31:0]                           regRdData,
  input  logic                                  hashMode,
  input  logic [$clog2(MAX_WORDS)-1:0]          keyIvWords,
  output logic                                  memReq,
  output logic [ADDR_W-1:0]                     memAddr,
  input  logic                                  memAck,
  input  logic                                  memErr,
  input  logic [WORD_W-1:0]                     memData,
  output logic                                  blkValid,
  input  logic                                  blkReady,
  output logic [MAX_WORDS*WORD_W-1:0]           blkData,
  output logic [$clog2(MAX_WORDS+1)-1:0]        blkWords,
  output logic                                  irqDigest,
  output logic                                  irqErr
);

  localparam int SLOT_W = $clog2(MAX_WORDS);

  pathStrobe_t       strobe;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  countVal;
  logic              enBit, errSticky;
  logic              unusedWr;

  assign unusedWr = ^regWrData;

  blockFetchCtrl #(
    .MAX_WORDS(MAX_WORDS), .CIPHER_WORDS(CIPHER_WORDS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel),
    .wrBit0(regWrData[0]), .wrCount(regWrData[CNT_LSB +: CNT_W]),
    .hashMode(hashMode), .keyIvWords(keyIvWords), .countVal(countVal),
    .memAck(memAck), .memErr(memErr), .blkReady(blkReady),
    .strobe(strobe), .slot(slot), .memReq(memReq), .blkValid(blkValid),
    .blkWords(blkWords), .irqDigest(irqDigest), .enBit(enBit), .errSticky(errSticky)
  );

  blockFetchPath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
  ) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .slot(slot),
    .addrIn(regWrData[ADDR_W-1:0]), .countIn(regWrData[CNT_LSB +: CNT_W]),
    .memData(memData), .addrVal(memAddr), .countVal(countVal), .blkData(blkData)
  );

  assign irqErr = errSticky;

  always_comb begin
    unique case (regSel)
      REG_CTRL: regRdData = (32'(countVal) << CNT_LSB) | 32'(enBit);
      REG_ADDR: regRdData = 32'(memAddr);
      REG_STAT: regRdData = 32'(errSticky);
      default:  regRdData = '0;
    endcase
  end

  // R6: an offered block is held unchanged until taken
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (rst)
    blkValid && !blkReady |=> blkValid && $stable(blkData) && $stable(blkWords));

  // R6: no fetching while a block waits
  a_r6_no_fetch_while_offer: assert property (@(posedge clk) disable iff (rst)
    blkValid |-> !memReq);

  // R4: address steps one word per good response
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck && !memErr |=> memAddr == $past(memAddr) + ADDR_W'(WORD_W/8));

  // R7: acceptance takes exactly one off the count
  a_r7_count_dec: assert property (@(posedge clk) disable iff (rst)
    blkValid && blkReady |=> countVal == $past(countVal) - CNT_W'(1));

  // R9: a failed read freezes count and address and stops requests
  a_r9_error_freeze: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck && memErr |=> !memReq && irqErr &&
      countVal == $past(countVal) && memAddr == $past(memAddr));

  // R10: pending error keeps the read port quiet
  a_r10_error_blocks: assert property (@(posedge clk) disable iff (rst)
    irqErr |-> !memReq);

endmodule

// File: tb/blockFetch_test.sv
module blockFetch_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         regWrEn = 1'b0;
  logic [1:0]   regSel = 2'd0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         hashMode = 1'b1;
  logic [3:0]   keyIvWords = '0;
  logic         memReq, memAck, memErr;
  logic [31:0]  memAddr, memData;
  logic         blkValid, blkReady = 1'b0;
  logic [511:0] blkData;
  logic [4:0]   blkWords;
  logic         irqDigest, irqErr;

  int checks = 0, errors = 0;
  int irqCnt = 0, reqCnt = 0;
  logic        errArm = 1'b0;
  logic [31:0] errAddr = '0;

  always #5 clk = ~clk;

  blockFetch uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .hashMode(hashMode), .keyIvWords(keyIvWords),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memErr(memErr), .memData(memData),
    .blkValid(blkValid), .blkReady(blkReady), .blkData(blkData), .blkWords(blkWords),
    .irqDigest(irqDigest), .irqErr(irqErr)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  // memory model: one-cycle acknowledge, error at a chosen address
  always @(posedge clk) begin
    if (rst) begin
      memAck  <= 1'b0;
      memErr  <= 1'b0;
      memData <= '0;
    end else begin
      memAck  <= memReq && !memAck;
      memErr  <= errArm && (memAddr == errAddr);
      memData <= memWord(memAddr);
    end
  end

  always @(posedge clk) begin
    if (irqDigest) irqCnt++;
    if (memReq) reqCnt++;
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    regSel = sel; regWrData = data; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] data);
    regSel = sel;
    #1;
    data = regRdData;
  endtask

  task automatic startJob(input bit hash, input int kiv, input logic [31:0] base, input int cnt);
    hashMode = hash; keyIvWords = 4'(kiv);
    writeReg(2'd1, base);
    writeReg(2'd0, (32'(cnt) << 16) | 32'd1);
  endtask

  // accept nBlk blocks, checking length, data order and count
  task automatic takeBlocks(input bit hash, input int kiv, input logic [31:0] base,
                            input int total, input int nBlk, input bit slowReady);
    logic [31:0] a = base;
    logic [31:0] rd;
    for (int b = 0; b < nBlk; b++) begin
      int t = 0;
      int len;
      int bad = 0;
      while (!blkValid && t < 400) begin tick(); t++; end
      check(blkValid, "R6 block offered", 64'(blkValid), 64'd1);
      len = hash ? 16 : (b == 0 ? 4 + (kiv > 12 ? 12 : kiv) : 4);
      check(blkWords == 5'(len), "R5 block length", 64'(blkWords), 64'(len));
      for (int w = 0; w < len; w++)
        if (blkData[w*32 +: 32] !== memWord(a + 32'(4*w))) bad++;
      check(bad == 0, "R4/R6 word order", 64'(bad), 64'd0);
      if (slowReady) begin
        tick(3);
        check(blkValid && !memReq, "R6 hold without fetch", {62'd0, blkValid, memReq}, 64'h2);
      end
      readReg(2'd0, rd);
      check(rd[26:16] == 11'(total - b), "R7 count before accept", 64'(rd[26:16]), 64'(total - b));
      blkReady = 1'b1;
      tick();
      blkReady = 1'b0;
      readReg(2'd0, rd);
      check(rd[26:16] == 11'(total - b - 1), "R7 count after accept", 64'(rd[26:16]), 64'(total - b - 1));
      a = a + 32'(4*len);
    end
  endtask

  task automatic testReset();
    logic [31:0] rd;
    readReg(2'd0, rd); check(rd == 0, "R1 control reset", 64'(rd), 64'd0);
    readReg(2'd1, rd); check(rd == 0, "R1 address reset", 64'(rd), 64'd0);
    readReg(2'd2, rd); check(rd == 0, "R1 status reset", 64'(rd), 64'd0);
    check(!memReq && !blkValid && !irqDigest && !irqErr, "R1 outputs idle",
          {60'd0, memReq, blkValid, irqDigest, irqErr}, 64'd0);
  endtask

  task automatic testNoStart();
    logic [31:0] rd;
    int r0 = reqCnt;
    writeReg(2'd0, 32'h0005_0000);           // count 5, enable 0
    readReg(2'd0, rd);
    check(rd == 32'h0005_0000, "R2 control layout", 64'(rd), 64'h50000);
    tick(8);
    check(reqCnt == r0, "R3 enable 0 no read", 64'(reqCnt - r0), 64'd0);
    writeReg(2'd0, 32'h0000_0001);           // count 0, enable 1
    readReg(2'd0, rd);
    check(rd == 32'h1, "R2 enable bit", 64'(rd), 64'h1);
    tick(8);
    check(reqCnt == r0, "R3 count 0 no read", 64'(reqCnt - r0), 64'd0);
  endtask

  task automatic testHash();
    logic [31:0] rd;
    int i0 = irqCnt;
    startJob(1'b1, 0, 32'h100, 2);
    takeBlocks(1'b1, 0, 32'h100, 2, 2, 1'b1);
    tick(4);
    check(irqCnt - i0 == 1, "R8 hash single irq", 64'(irqCnt - i0), 64'd1);
    readReg(2'd1, rd);
    check(rd == 32'h180, "R4 final address", 64'(rd), 64'h180);
    check(!memReq, "R7 stops at zero", 64'(memReq), 64'd0);
  endtask

  task automatic testCipher();
    int i0 = irqCnt;
    startJob(1'b0, 4, 32'h300, 3);
    takeBlocks(1'b0, 4, 32'h300, 3, 3, 1'b0);
    tick(4);
    check(irqCnt - i0 == 3, "R8 cipher irq per block", 64'(irqCnt - i0), 64'd3);
    i0 = irqCnt;
    startJob(1'b0, 15, 32'h340, 1);             // clamp case
    takeBlocks(1'b0, 15, 32'h340, 1, 1, 1'b0);
    tick(4);
    check(irqCnt - i0 == 1, "R8 cipher single block irq", 64'(irqCnt - i0), 64'd1);
  endtask

  task automatic testBusyWrites();
    logic [31:0] rd;
    startJob(1'b0, 0, 32'h200, 2);
    tick(2);
    writeReg(2'd1, 32'h000D_EAD0);
    writeReg(2'd0, 32'h0007_0001);
    takeBlocks(1'b0, 0, 32'h200, 2, 2, 1'b0);
    tick(2);
    readReg(2'd1, rd);
    check(rd == 32'h220, "R11 address write ignored", 64'(rd), 64'h220);
    readReg(2'd0, rd);
    check(rd[26:16] == 0, "R11 count write ignored", 64'(rd[26:16]), 64'd0);
  endtask

  task automatic testError();
    logic [31:0] rd;
    int t = 0;
    int r0;
    errAddr = 32'h400 + 32'd64 + 32'd8;
    errArm  = 1'b1;
    startJob(1'b1, 0, 32'h400, 3);
    takeBlocks(1'b1, 0, 32'h400, 3, 1, 1'b0);
    while (!irqErr && t < 400) begin tick(); t++; end
    check(irqErr, "R9 error interrupt", 64'(irqErr), 64'd1);
    tick(2);
    readReg(2'd0, rd);
    check(rd[26:16] == 2, "R9 count holds failed block", 64'(rd[26:16]), 64'd2);
    readReg(2'd1, rd);
    check(rd == errAddr, "R9 address at failing word", 64'(rd), 64'(errAddr));
    readReg(2'd2, rd);
    check(rd == 1, "R9 sticky status", 64'(rd), 64'd1);
    check(!memReq && !blkValid, "R9 transfer stopped", {62'd0, memReq, blkValid}, 64'd0);
    errArm = 1'b0;
    r0 = reqCnt;
    startJob(1'b1, 0, 32'h800, 1);
    tick(8);
    check(reqCnt == r0, "R10 start blocked by error", 64'(reqCnt - r0), 64'd0);
    writeReg(2'd2, 32'h1);
    readReg(2'd2, rd);
    check(rd == 0 && !irqErr, "R10 error cleared", 64'(rd), 64'd0);
    startJob(1'b1, 0, 32'h800, 1);
    takeBlocks(1'b1, 0, 32'h800, 1, 1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    testReset();
    testNoStart();
    testHash();
    testCipher();
    testBusyWrites();
    testError();
    tick(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule